// File: doc/BRIEF.md
# Filtered Trace Capture Controller

The block records the bus activity of an embedded processor into an on-chip trace memory. One 80-bit frame is stored per executed bus cycle. It holds the address, the data, four cycle-type controls, a slice of the port pins, eight user logic inputs and a 32-bit absolute timestamp. The timestamp counter is kept inside the block and advances on a clock-enable tick, normally one tick per 100 ns. Relative and delta times are left to host software, which takes differences of the stored values.

Event logic outside the block drives two qualifiers. A start pulse opens recording and a stop pulse closes it. An optional frame limit ends recording once a programmed number of frames has been stored since the last rearm. The write pointer wraps around the buffer. When the stop-on-full option is set, the buffer instead freezes at its first wrap. A full flag reports that the buffer has been filled at least once, and it can feed a breakpoint. A host read port with one cycle of latency reads any stored frame while capture goes on, and capture is never stalled by it.

The memory depth is a parameter. The default is 1024 entries, and setting `ADDR_W=15` gives the full 32768-frame buffer.

Top module: `trace_capture`

## Requirements
- R1: After reset, `wr_ptr_o` is 0, `trace_full_o` is 0, `recording_o` is 0, `host_rd_valid_o` is 0 and `tstamp_o` is 0.
- R2: A stored frame has this layout: bits [15:0] address, [23:16] data, [24] read, [25] write, [26] fetch, [27] interrupt, [39:28] port pins, [47:40] user inputs, [79:48] the value of `tstamp_o` during the stored cycle.
- R3: A cycle with `cyc_valid_i` high is stored only while recording is active. Recording becomes active through `start_evt_i`, and the cycle that carries the start pulse is itself stored. When no start has been seen, valid cycles leave `wr_ptr_o` unchanged.
- R4: A cycle that carries `stop_evt_i` is not stored, and `recording_o` is 0 after it. When start and stop come in the same cycle, stop wins.
- R5: Each stored frame is written at address `wr_ptr_o`, and `wr_ptr_o` then advances by one. When `stop_on_full_i` is 0, the pointer wraps from the last address to 0 and older frames are overwritten.
- R6: `trace_full_o` sets after a write to the last address and stays set until rearm. While it is set with `stop_on_full_i` high, no frame is stored, `wr_ptr_o` holds, and `recording_o` is 0.
- R7: With `limit_en_i` high, once `limit_i` frames have been stored since the last rearm, no further frame is stored, `recording_o` drops, and a new start pulse has no effect. A limit of 0 stores nothing.
- R8: `tstamp_o` advances by one on each cycle with `tick_i` high, holds otherwise, and wraps modulo 2^32.
- R9: When `host_rd_en_i` is high, the frame at `host_rd_addr_i` appears on `host_rd_data_o` with `host_rd_valid_o` high one cycle later. This works during capture and does not disturb it.
- R10: `rearm_i` clears `wr_ptr_o`, `trace_full_o`, recording and the frame count, and stores nothing in its cycle. It does not change `tstamp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timestamp clock enable (100 ns) |
| cyc_valid_i | input | 1 | An executed bus cycle is present |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus data |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| fetch_i | input | 1 | Opcode fetch |
| irq_i | input | 1 | Interrupt acknowledge |
| port_i | input | 12 | Port pin snapshot |
| user_i | input | 8 | User logic inputs |
| start_evt_i | input | 1 | Start qualifier event |
| stop_evt_i | input | 1 | Stop qualifier event |
| rearm_i | input | 1 | Restart a capture session |
| limit_en_i | input | 1 | Enable the frame limit |
| limit_i | input | CNT_W | Frame limit |
| stop_on_full_i | input | 1 | Freeze the buffer at first wrap |
| host_rd_en_i | input | 1 | Host read request |
| host_rd_addr_i | input | ADDR_W | Host read address |
| host_rd_data_o | output | 80 | Frame read out |
| host_rd_valid_o | output | 1 | Read data valid |
| wr_ptr_o | output | ADDR_W | Next write address |
| trace_full_o | output | 1 | Buffer filled at least once |
| recording_o | output | 1 | Recording active |
| tstamp_o | output | 32 | Current timestamp |

## Verification
Qualification is driven with several patterns: valid cycles with no start, a start followed by a stop, start and stop in the same cycle, and runs longer than the buffer with the wrap and freeze options. Together these separate "stored", "not stored" and "stopped" at the exact cycle where each takes effect. Frames are read back with a different stimulus pattern on every field and a timestamp that ticks only on some cycles, so a misplaced field or a timestamp taken one cycle off shows up. The frame limit is tried at a nonzero value and at zero, and again with a later start pulse. Rearm is applied while start and valid are asserted, so that a stray store in the rearm cycle or a timestamp reset would be seen.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned ADDRB_W = 16;
  localparam int unsigned DATAB_W = 8;
  localparam int unsigned PORT_W  = 12;
  localparam int unsigned USER_W  = 8;
  localparam int unsigned TS_W    = 32;

  typedef struct packed {
    logic [TS_W-1:0]    ts;
    logic [USER_W-1:0]  user;
    logic [PORT_W-1:0]  port;
    logic               irq;
    logic               fetch;
    logic               wr;
    logic               rd;
    logic [DATAB_W-1:0] data;
    logic [ADDRB_W-1:0] addr;
  } frame_t;

  localparam int unsigned FRAME_W = $bits(frame_t);
endpackage

// File: rtl/trace_tstamp.sv
module trace_tstamp #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ts_q <= '0;
    else if (tick_i) ts_q <= ts_q + 1'b1;
  end

  assign ts_o = ts_q;

  assert_ts_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ts_q == TS_W'($past(ts_q) + 1'b1));
  assert_ts_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ts_q));
endmodule

// File: rtl/trace_qual.sv
module trace_qual #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rearm_i,
  input  logic              lim_en_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic              sof_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              full_o,
  output logic              rec_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d, rec_q, rec_d;
  logic              blocked, blocked_d, eff, ptr_last;

  assign blocked  = (lim_en_i && (cnt_q >= lim_i)) || (sof_i && full_q);
  // stop outranks start; rearm cycle never stores
  assign eff      = (rec_q | start_i) & ~stop_i & ~blocked & ~rearm_i;
  assign we_o     = valid_i & eff;
  assign ptr_last = &ptr_q;

  always_comb begin
    cnt_d = cnt_q;
    if (we_o && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  assign full_d    = full_q | (we_o & ptr_last);
  assign blocked_d = (lim_en_i && (cnt_d >= lim_i)) || (sof_i && full_d);
  assign rec_d     = (rec_q | start_i) & ~stop_i & ~blocked_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      rec_q  <= 1'b0;
    end else if (rearm_i) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      rec_q  <= 1'b0;
    end else begin
      if (we_o) ptr_q <= ptr_q + 1'b1;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      rec_q  <= rec_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;
  assign rec_o  = rec_q;

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !rearm_i) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
  assert_ptr_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_o && !rearm_i) |=> $stable(ptr_q));
  assert_stop_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !rec_q);
  assert_full_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rearm_i) |=> full_q);
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && sof_i && !rearm_i) |=> $stable(ptr_q));
  assert_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_en_i && (cnt_q >= lim_i) && !rearm_i) |=> $stable(cnt_q));
  assert_rearm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (ptr_q == '0) && !full_q && !rec_q && (cnt_q == '0));
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on a same-address collision
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= re_i;
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_rd_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_q);
  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_q);
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               cyc_valid_i,
  input  logic [ADDRB_W-1:0] addr_i,
  input  logic [DATAB_W-1:0] data_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               fetch_i,
  input  logic               irq_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic [USER_W-1:0]  user_i,
  input  logic               start_evt_i,
  input  logic               stop_evt_i,
  input  logic               rearm_i,
  input  logic               limit_en_i,
  input  logic [CNT_W-1:0]   limit_i,
  input  logic               stop_on_full_i,
  input  logic               host_rd_en_i,
  input  logic [ADDR_W-1:0]  host_rd_addr_i,
  output logic [FRAME_W-1:0] host_rd_data_o,
  output logic               host_rd_valid_o,
  output logic [ADDR_W-1:0]  wr_ptr_o,
  output logic               trace_full_o,
  output logic               recording_o,
  output logic [TS_W-1:0]    tstamp_o
);
  logic [TS_W-1:0]   ts;
  logic              we;
  logic [ADDR_W-1:0] ptr;
  frame_t            frame;

  trace_tstamp #(.TS_W(TS_W)) u_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .ts_o  (ts)
  );

  trace_qual #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cyc_valid_i),
    .start_i (start_evt_i),
    .stop_i  (stop_evt_i),
    .rearm_i (rearm_i),
    .lim_en_i(limit_en_i),
    .lim_i   (limit_i),
    .sof_i   (stop_on_full_i),
    .we_o    (we),
    .ptr_o   (ptr),
    .full_o  (trace_full_o),
    .rec_o   (recording_o)
  );

  always_comb begin
    frame.ts    = ts;
    frame.user  = user_i;
    frame.port  = port_i;
    frame.irq   = irq_i;
    frame.fetch = fetch_i;
    frame.wr    = wr_i;
    frame.rd    = rd_i;
    frame.data  = data_i;
    frame.addr  = addr_i;
  end

  trace_mem #(.ADDR_W(ADDR_W), .DATA_W(FRAME_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (ptr),
    .wdata_i (frame),
    .re_i    (host_rd_en_i),
    .raddr_i (host_rd_addr_i),
    .rdata_o (host_rd_data_o),
    .rvalid_o(host_rd_valid_o)
  );

  assign wr_ptr_o = ptr;
  assign tstamp_o = ts;

  assert_idle_no_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!recording_o && !start_evt_i && !rearm_i) |=> $stable(wr_ptr_o));
  assert_ts_untouched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_i && !tick_i) |=> $stable(tstamp_o));
endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
  localparam int unsigned AW = 4;
  localparam int unsigned CW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, cyc_valid_i = 0, rd_i = 0, wr_i = 0, fetch_i = 0, irq_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0, user_i = '0;
  logic [11:0] port_i = '0;
  logic start_evt_i = 0, stop_evt_i = 0, rearm_i = 0, limit_en_i = 0, stop_on_full_i = 0;
  logic [CW-1:0] limit_i = '0;
  logic host_rd_en_i = 0;
  logic [AW-1:0] host_rd_addr_i = '0;
  logic [79:0] host_rd_data_o;
  logic host_rd_valid_o, trace_full_o, recording_o;
  logic [AW-1:0] wr_ptr_o;
  logic [31:0] tstamp_o;

  always #2 clk = ~clk;

  trace_capture #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cyc_valid_i(cyc_valid_i),
    .addr_i(addr_i), .data_i(data_i), .rd_i(rd_i), .wr_i(wr_i), .fetch_i(fetch_i),
    .irq_i(irq_i), .port_i(port_i), .user_i(user_i), .start_evt_i(start_evt_i),
    .stop_evt_i(stop_evt_i), .rearm_i(rearm_i), .limit_en_i(limit_en_i),
    .limit_i(limit_i), .stop_on_full_i(stop_on_full_i), .host_rd_en_i(host_rd_en_i),
    .host_rd_addr_i(host_rd_addr_i), .host_rd_data_o(host_rd_data_o),
    .host_rd_valid_o(host_rd_valid_o), .wr_ptr_o(wr_ptr_o), .trace_full_o(trace_full_o),
    .recording_o(recording_o), .tstamp_o(tstamp_o)
  );

  int checks = 0, failures = 0, seq = 0;
  bit finished = 0;
  logic [79:0] exp_mem [16];
  logic [AW-1:0] ptr_m = '0;
  logic [CW-1:0] cnt_m = '0;
  bit full_m = 0, rec_m = 0;
  logic [31:0] ts_m = '0;

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle; reference model follows the requirements
  task automatic step(input bit v, input bit st, input bit sp, input bit ra);
    logic [79:0] fr;
    bit blk, eff, str, blk2, tk;
    logic [CW-1:0] cnt_n;
    bit full_n;
    tk = seq[0];
    addr_i = 16'h1000 + 16'(seq * 7);
    data_i = 8'(seq * 3 + 1);
    {irq_i, fetch_i, wr_i, rd_i} = 4'(seq);
    port_i = 12'hA00 ^ 12'(seq);
    user_i = 8'h5A + 8'(seq);
    seq++;
    cyc_valid_i = v; start_evt_i = st; stop_evt_i = sp; rearm_i = ra; tick_i = tk;
    fr = {ts_m, user_i, port_i, irq_i, fetch_i, wr_i, rd_i, data_i, addr_i};
    blk = (limit_en_i && cnt_m >= limit_i) || (stop_on_full_i && full_m);
    eff = (rec_m | st) & ~sp & ~blk & ~ra;
    str = v & eff;
    @(posedge clk);
    @(negedge clk);
    if (ra) begin
      ptr_m = '0; cnt_m = '0; full_m = 0; rec_m = 0;
    end else begin
      cnt_n = cnt_m; full_n = full_m;
      if (str) begin
        exp_mem[ptr_m] = fr;
        if (ptr_m == AW'(15)) full_n = 1;
        ptr_m = ptr_m + 1'b1;
        if (cnt_m != '1) cnt_n = cnt_m + 1'b1;
      end
      blk2 = (limit_en_i && cnt_n >= limit_i) || (stop_on_full_i && full_n);
      rec_m = (rec_m | st) & ~sp & ~blk2;
      cnt_m = cnt_n; full_m = full_n;
    end
    if (tk) ts_m = ts_m + 1;
    cyc_valid_i = 0; start_evt_i = 0; stop_evt_i = 0; rearm_i = 0; tick_i = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a);
    host_rd_en_i = 1; host_rd_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    host_rd_en_i = 0;
    chk({tag, " rd_valid"}, 80'(host_rd_valid_o), 80'(1));
    chk({tag, " frame"}, host_rd_data_o, exp_mem[a]);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " wr_ptr"}, 80'(wr_ptr_o), 80'(ptr_m));
    chk({tag, " full"}, 80'(trace_full_o), 80'(full_m));
    chk({tag, " rec"}, 80'(recording_o), 80'(rec_m));
  endtask

  task automatic t_reset;
    chk("R1 wr_ptr", 80'(wr_ptr_o), 80'(0));
    chk("R1 full", 80'(trace_full_o), 80'(0));
    chk("R1 rec", 80'(recording_o), 80'(0));
    chk("R1 rd_valid", 80'(host_rd_valid_o), 80'(0));
    chk("R1 tstamp", 80'(tstamp_o), 80'(0));
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    chk("R3 idle no store", 80'(wr_ptr_o), 80'(0));
  endtask

  task automatic t_start_stop;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    chk("R3 start stores", 80'(wr_ptr_o), 80'(4));
    step(1, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R4 stop not stored", 80'(wr_ptr_o), 80'(4));
    chk("R4 rec after stop", 80'(recording_o), 80'(0));
    for (int i = 0; i < 4; i++) rd_chk("R2", AW'(i));
    step(1, 1, 1, 0);
    chk("R4 stop wins ptr", 80'(wr_ptr_o), 80'(4));
    chk("R4 stop wins rec", 80'(recording_o), 80'(0));
  endtask

  task automatic t_ts;
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0);
    chk("R8 tstamp", 80'(tstamp_o), 80'(ts_m));
  endtask

  task automatic t_wrap;
    stop_on_full_i = 0;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    for (int i = 0; i < 19; i++) step(1, 0, 0, 0);
    chk_state("R5 wrap");
    chk("R6 full after wrap", 80'(trace_full_o), 80'(1));
    rd_chk("R5 overwritten", AW'(1));
    rd_chk("R5 old entry", AW'(9));
  endtask

  task automatic t_sof;
    stop_on_full_i = 1;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    for (int i = 0; i < 19; i++) step(1, 0, 0, 0);
    chk("R6 freeze ptr", 80'(wr_ptr_o), 80'(0));
    chk_state("R6 freeze");
    rd_chk("R6 first frame kept", AW'(0));
    stop_on_full_i = 0;
  endtask

  task automatic t_limit;
    limit_en_i = 1; limit_i = 5;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0);
    chk("R7 limit ptr", 80'(wr_ptr_o), 80'(5));
    chk("R7 limit rec", 80'(recording_o), 80'(0));
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 restart ignored", 80'(wr_ptr_o), 80'(5));
    limit_i = 0;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 zero limit", 80'(wr_ptr_o), 80'(0));
    chk_state("R7 zero limit");
    limit_en_i = 0;
  endtask

  task automatic t_read_during;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    host_rd_en_i = 1; host_rd_addr_i = AW'(0);
    step(1, 0, 0, 0);
    host_rd_en_i = 0;
    chk("R9 read during capture valid", 80'(host_rd_valid_o), 80'(1));
    chk("R9 read during capture data", host_rd_data_o, exp_mem[0]);
    chk("R9 capture undisturbed", 80'(wr_ptr_o), 80'(3));
    rd_chk("R9 frame written alongside read", AW'(2));
  endtask

  task automatic t_rearm;
    chk("R10 pre rec", 80'(recording_o), 80'(1));
    step(1, 1, 0, 1);
    chk_state("R10 rearm");
    chk("R10 ptr zero", 80'(wr_ptr_o), 80'(0));
    chk("R10 tstamp kept", 80'(tstamp_o), 80'(ts_m));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_idle;
    t_start_stop;
    t_ts;
    t_wrap;
    t_sof;
    t_limit;
    t_read_during;
    t_rearm;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule